// File: doc/BRIEF.md
# Pixel Bus Formatter

The formatter sits between a pixel word stream and the parallel data pins of a display panel. Words arrive one per beat over a valid/ready handshake and wait in a small word queue. Each time the timing generator pulses the pixel-enable strobe, the formatter presents the next pixel on the panel data bus. That pixel is laid out for the configured bus width (16, 18 or 24 lines) and for the configured input word length. Two input layouts are handled. The first packs two RGB565 pixels into each 32-bit word, low halfword first. The second carries one pixel per 32-bit word with 8 bits for each colour, and its top byte is never shown.

A per-byte valid mask zeroes bytes of the input word before they are mapped. A narrowing flag drops the two least significant bits of each 8-bit colour so that the colour fits an 18-line bus. A queue-clear control discards every buffered word and restarts the halfword phase, which lets software reconfigure the block without shifting the image. If the queue is empty at a strobe, the bus shows zero and a sticky starvation flag is set. Unsupported settings raise a configuration error and blank the output: the 8-line bus code, and the word length codes 1 and 2.

The sequencer has three states. `ST_LOW` means the next strobe takes the low half of a packed word, or the whole word in 32-bit mode. `ST_HIGH` means the next strobe takes the high half. `ST_FAULT` means the configuration is unsupported. The transitions are as follows. *split*: `ST_LOW` goes to `ST_HIGH` on a fed strobe in 16-bit mode. *finish*: `ST_HIGH` goes to `ST_LOW` on a fed strobe, and the word is popped. *trip*: `ST_LOW` or `ST_HIGH` goes to `ST_FAULT` when the configuration is unsupported. *recover*: `ST_FAULT` goes to `ST_LOW` once the configuration is valid. *restart*: a queue clear sends any state to `ST_LOW`, or to `ST_FAULT` if the configuration is still unsupported.

Top module: `pixel_bus_formatter`

## Requirements
- R1: After reset, pan_data is 0, underflow is 0, cfg_error is 0 and in_ready is 1.
- R2: The queue holds DEPTH words. in_ready is low while the queue is full. A word is taken only on a cycle with in_valid and in_ready both high, and words leave the queue in arrival order.
- R3: With word length code 0 (16-bit pixels), each word yields two pixels. Bits 15:0 are shown first and bits 31:16 second, and the word leaves the queue on the second strobe.
- R4: A 16-bit pixel uses RGB565, with red in 15:11, green in 10:5 and blue in 4:0. Bus code 0 (16 lines) shows the pixel as is on pan_data[15:0]. Bus code 2 (18 lines) shows {r, r[4], g, b, b[4]}. Bus code 3 (24 lines) shows {r, r[4:2], g, g[5:4], b, b[4:2]}. All unused upper bits of pan_data are 0.
- R5: With word length code 3, each word yields one pixel: red in 23:16, green in 15:8 and blue in 7:0. Bits 31:24 have no effect. On bus code 3 with narrowing off, pan_data is {R, G, B}.
- R6: With word length code 3, when narrowing is on or the bus code is 2, pan_data[17:0] is {R[7:2], G[7:2], B[7:2]}. On bus code 0 with narrowing off, pan_data[15:0] is {R[7:3], G[7:2], B[7:3]}.
- R7: When bit i of cfg_byte_mask is 0, byte i (bits 8i+7:8i) of every word is treated as zero before mapping.
- R8: pan_data changes only in the cycle after a pix_en strobe and holds its value in all other cycles.
- R9: A strobe while the queue is empty makes pan_data 0 and sets underflow. underflow stays set until a queue clear or reset.
- R10: fifo_clear empties the queue, returns the halfword phase to the low half and clears underflow. in_ready is low during the clear cycle.
- R11: Bus code 1, or word length code 1 or 2, sets cfg_error from the next cycle on. While cfg_error is set, strobes give 0, consume no word and do not set underflow. cfg_error drops one cycle after the configuration becomes valid again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus_width | input | 2 | Panel bus code: 0=16, 1=8 (unsupported), 2=18, 3=24 lines |
| cfg_word_len | input | 2 | Input layout: 0=packed RGB565, 3=one 8:8:8 pixel per word |
| cfg_narrow | input | 1 | Drop the two low bits of each 8-bit colour |
| cfg_byte_mask | input | WORD_W/8 | Per-byte valid mask of the input word |
| fifo_clear | input | 1 | Discard queued words, reset phase and underflow |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Input word |
| in_ready | output | 1 | Queue can accept a word |
| pix_en | input | 1 | Pixel-enable strobe from the timing generator |
| pan_data | output | PAN_W | Panel data bus |
| underflow | output | 1 | Sticky starvation flag |
| cfg_error | output | 1 | Unsupported configuration |

## Verification
A stuck or skipped halfword phase shows at the first strobe pair of a packed word: either one half repeats, or the next word's low half comes out a pixel early. This error persists for the rest of the frame. A queue pointer that is off by one gives stale or reordered pixels within a few strobes after the queue has been filled. It can also drop in_ready one word early, which is visible as soon as DEPTH words have been offered. An incorrect fault transition shows on the strobe after the configuration changes, as a non-zero pixel, a lost word or a spurious underflow.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
    localparam logic [1:0] BUS_16 = 2'd0;
    localparam logic [1:0] BUS_8  = 2'd1;
    localparam logic [1:0] BUS_18 = 2'd2;
    localparam logic [1:0] BUS_24 = 2'd3;

    localparam logic [1:0] WL_16 = 2'd0;
    localparam logic [1:0] WL_32 = 2'd3;

    typedef enum logic [1:0] {
        ST_LOW   = 2'd0,
        ST_HIGH  = 2'd1,
        ST_FAULT = 2'd2
    } fmt_state_e;
endpackage

// File: rtl/pfmt_word_fifo.sv
module pfmt_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clear) |=> full);
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/pfmt_pixel_map.sv
module pfmt_pixel_map
    import pfmt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PAN_W  = 24
) (
    input  logic [WORD_W-1:0]   word,
    input  logic [WORD_W/8-1:0] byte_mask,
    input  logic                sel_high,
    input  logic                wide_word,
    input  logic [1:0]          bus_code,
    input  logic                narrow,
    output logic [PAN_W-1:0]    pix
);
    localparam int BYTES = WORD_W / 8;

    logic [WORD_W-1:0] masked;
    logic [15:0]       half;
    logic [4:0]        r5, b5;
    logic [5:0]        g6;
    logic [7:0]        r8, g8, b8;
    logic [23:0]       v24;

    for (genvar i = 0; i < BYTES; i++) begin : g_mask
        assign masked[8*i +: 8] = byte_mask[i] ? word[8*i +: 8] : 8'h00;
    end

    assign half = sel_high ? masked[31:16] : masked[15:0];
    assign r5   = half[15:11];
    assign g6   = half[10:5];
    assign b5   = half[4:0];
    assign r8   = masked[23:16];
    assign g8   = masked[15:8];
    assign b8   = masked[7:0];

    always_comb begin
        v24 = '0;
        if (!wide_word) begin
            unique case (bus_code)
                BUS_18:  v24 = {6'd0, r5, r5[4], g6, b5, b5[4]};
                BUS_24:  v24 = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
                default: v24 = {8'd0, half};
            endcase
        end else if (narrow || bus_code == BUS_18) begin
            v24 = {6'd0, r8[7:2], g8[7:2], b8[7:2]};
        end else if (bus_code == BUS_24) begin
            v24 = {r8, g8, b8};
        end else begin
            v24 = {8'd0, r8[7:3], g8[7:2], b8[7:3]};
        end
    end

    assign pix = PAN_W'(v24);
endmodule

// File: rtl/pfmt_seq.sv
module pfmt_seq
    import pfmt_pkg::*;
#(
    parameter int PAN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pix_en,
    input  logic             bad_cfg,
    input  logic             wide_word,
    input  logic             fifo_empty,
    input  logic [PAN_W-1:0] mapped,
    output logic             pop,
    output logic             sel_high,
    output logic [PAN_W-1:0] pan_data,
    output logic             underflow,
    output logic             cfg_error
);
    fmt_state_e state_q, state_d;
    logic       fed;

    assign fed       = pix_en && !fifo_empty && !bad_cfg && !clear;
    assign sel_high  = (state_q == ST_HIGH) && !wide_word;
    assign cfg_error = (state_q == ST_FAULT);

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            ST_LOW: begin
                if (bad_cfg) state_d = ST_FAULT;
                else if (fed) begin
                    if (wide_word) pop = 1'b1;
                    else state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (bad_cfg) state_d = ST_FAULT;
                else if (fed) begin
                    pop     = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_FAULT: begin
                if (!bad_cfg) state_d = ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_LOW;
        else if (clear) state_q <= bad_cfg ? ST_FAULT : ST_LOW;
        else            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pan_data  <= '0;
            underflow <= 1'b0;
        end else begin
            if (pix_en) begin
                if (fed && state_q != ST_FAULT) pan_data <= mapped;
                else                           pan_data <= '0;
            end
            if (clear) underflow <= 1'b0;
            else if (pix_en && fifo_empty && !bad_cfg && state_q != ST_FAULT)
                underflow <= 1'b1;
        end
    end

    p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);
    p_fault_blanks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_error && pix_en) |=> (pan_data == '0));
    p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clear) |=> underflow);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pan_data));
    p_high_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && fed) |-> pop);
endmodule

// File: rtl/pixel_bus_formatter.sv
module pixel_bus_formatter
    import pfmt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PAN_W  = 24,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_bus_width,
    input  logic [1:0]          cfg_word_len,
    input  logic                cfg_narrow,
    input  logic [WORD_W/8-1:0] cfg_byte_mask,
    input  logic                fifo_clear,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    input  logic                pix_en,
    output logic [PAN_W-1:0]    pan_data,
    output logic                underflow,
    output logic                cfg_error
);
    logic [WORD_W-1:0] head;
    logic              empty, full, pop, sel_high, bad_cfg, wide_word;
    logic [PAN_W-1:0]  mapped;

    assign wide_word = (cfg_word_len == WL_32);
    assign bad_cfg   = (cfg_bus_width == BUS_8) ||
                       (cfg_word_len != WL_16 && cfg_word_len != WL_32);
    assign in_ready  = !full && !fifo_clear;

    pfmt_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
        .push(in_valid && in_ready), .push_data(in_data), .pop(pop),
        .head(head), .empty(empty), .full(full)
    );

    pfmt_pixel_map #(.WORD_W(WORD_W), .PAN_W(PAN_W)) u_map (
        .word(head), .byte_mask(cfg_byte_mask), .sel_high(sel_high),
        .wide_word(wide_word), .bus_code(cfg_bus_width),
        .narrow(cfg_narrow), .pix(mapped)
    );

    pfmt_seq #(.PAN_W(PAN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .pix_en(pix_en),
        .bad_cfg(bad_cfg), .wide_word(wide_word), .fifo_empty(empty),
        .mapped(mapped), .pop(pop), .sel_high(sel_high),
        .pan_data(pan_data), .underflow(underflow), .cfg_error(cfg_error)
    );

    p_ready_low_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready);
endmodule

// File: tb/pixel_bus_formatter_test.sv
`timescale 1ns/1ps
module pixel_bus_formatter_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_bus_width = 2'd3;
    logic [1:0]  cfg_word_len = 2'd3;
    logic        cfg_narrow = 1'b0;
    logic [3:0]  cfg_byte_mask = 4'hF;
    logic        fifo_clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        pix_en = 1'b0;
    logic [23:0] pan_data;
    logic        underflow, cfg_error;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pixel_bus_formatter #(.WORD_W(32), .PAN_W(24), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_bus_width(cfg_bus_width),
        .cfg_word_len(cfg_word_len), .cfg_narrow(cfg_narrow),
        .cfg_byte_mask(cfg_byte_mask), .fifo_clear(fifo_clear),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .pix_en(pix_en), .pan_data(pan_data), .underflow(underflow),
        .cfg_error(cfg_error)
    );

    function automatic logic [23:0] exp_pix(input logic [31:0] w, input logic [3:0] m,
                                            input logic [1:0] wl, input logic [1:0] bus,
                                            input logic nar, input logic hi);
        logic [31:0] x;
        logic [15:0] p;
        logic [7:0]  r, g, b;
        for (int i = 0; i < 4; i++) x[8*i +: 8] = m[i] ? w[8*i +: 8] : 8'h00;
        if (wl == 2'd0) begin
            p = hi ? x[31:16] : x[15:0];
            if (bus == 2'd2) return {6'd0, p[15:11], p[15], p[10:5], p[4:0], p[4]};
            if (bus == 2'd3) return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
            return {8'd0, p};
        end
        r = x[23:16]; g = x[15:8]; b = x[7:0];
        if (nar || bus == 2'd2) return {6'd0, r[7:2], g[7:2], b[7:2]};
        if (bus == 2'd3) return {r, g, b};
        return {8'd0, r[7:3], g[7:2], b[7:3]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] bus, input logic [1:0] wl,
                           input logic nar, input logic [3:0] m);
        @(negedge clk);
        cfg_bus_width = bus; cfg_word_len = wl; cfg_narrow = nar; cfg_byte_mask = m;
    endtask

    task automatic do_clear(input bit check_ready);
        @(negedge clk);
        fifo_clear = 1'b1;
        #0.5;
        if (check_ready) chk("R10 ready low in clear", in_ready, 0);
        @(negedge clk);
        fifo_clear = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] words [DEPTH];
        logic [23:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 pan_data", pan_data, 0);
        chk("R1 underflow", underflow, 0);
        chk("R1 cfg_error", cfg_error, 0);
        chk("R1 in_ready", in_ready, 1);
        rst_n = 1'b1;

        // Directed: packed order R3
        set_cfg(2'd0, 2'd0, 1'b0, 4'hF);
        do_clear(1);
        push_word(32'hABCD_1234);
        strobe(); chk("R3 low half first", pan_data, 32'h1234);
        strobe(); chk("R3 high half second", pan_data, 32'hABCD);
        strobe(); chk("R9 starved pixel zero", pan_data, 0);
        chk("R9 underflow set", underflow, 1);
        repeat (3) @(negedge clk);
        chk("R9 underflow sticky", underflow, 1);

        // Directed: top byte ignored R5, byte mask R7
        set_cfg(2'd3, 2'd3, 1'b0, 4'hF);
        do_clear(0);
        chk("R10 underflow cleared", underflow, 0);
        push_word(32'hFF11_2233);
        strobe(); chk("R5 top byte ignored", pan_data, 32'h112233);
        set_cfg(2'd3, 2'd3, 1'b0, 4'h3);
        push_word(32'h00AA_BBCC);
        strobe(); chk("R7 masked byte zero", pan_data, 32'h00BBCC);
        held = pan_data;
        repeat (4) @(negedge clk);
        chk("R8 holds without strobe", pan_data, held);

        // Directed: full queue R2
        set_cfg(2'd3, 2'd3, 1'b0, 4'hF);
        do_clear(0);
        for (int i = 0; i < DEPTH; i++) push_word(32'h0010_0000 + i);
        chk("R2 ready low when full", in_ready, 0);
        @(negedge clk); in_valid = 1'b1; in_data = 32'h00EE_EEEE;
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            strobe(); chk("R2 order kept", pan_data, 32'h0010_0000 + i);
        end
        strobe(); chk("R2 extra word dropped", pan_data, 0);

        // Directed: clear resets phase R10
        set_cfg(2'd0, 2'd0, 1'b0, 4'hF);
        do_clear(0);
        push_word(32'h5555_AAAA);
        strobe();
        do_clear(0);
        push_word(32'h7777_3333);
        strobe(); chk("R10 phase back to low", pan_data, 32'h3333);

        // Directed: configuration error R11
        set_cfg(2'd1, 2'd3, 1'b0, 4'hF);
        do_clear(0);
        @(negedge clk);
        chk("R11 cfg_error 8-line bus", cfg_error, 1);
        push_word(32'h0012_3456);
        strobe(); chk("R11 blanked output", pan_data, 0);
        chk("R11 no underflow", underflow, 0);
        set_cfg(2'd3, 2'd3, 1'b0, 4'hF);
        @(negedge clk);
        chk("R11 cfg_error drops", cfg_error, 0);
        strobe(); chk("R11 word not consumed", pan_data, 32'h123456);
        set_cfg(2'd3, 2'd1, 1'b0, 4'hF);
        @(negedge clk);
        chk("R11 cfg_error word length 1", cfg_error, 1);

        // Random phases R4 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            logic [1:0] bus, wl;
            logic       nar;
            logic [3:0] m;
            int         n;
            string      tag;
            case ($urandom % 3)
                0: bus = 2'd0;
                1: bus = 2'd2;
                default: bus = 2'd3;
            endcase
            wl  = ($urandom % 2) ? 2'd3 : 2'd0;
            nar = 1'($urandom % 2);
            case ($urandom % 4)
                0: m = 4'($urandom);
                1: m = 4'h7;
                default: m = 4'hF;
            endcase
            n = 1 + int'($urandom % DEPTH);
            set_cfg(bus, wl, nar, m);
            do_clear(0);
            for (int k = 0; k < n; k++) begin
                words[k] = $urandom;
                push_word(words[k]);
            end
            if (m != 4'hF && m != 4'h7) tag = "R7";
            else if (wl == 2'd0) tag = "R4";
            else if (nar || bus != 2'd3) tag = "R6";
            else tag = "R5";
            for (int k = 0; k < n; k++) begin
                strobe(); chk(tag, pan_data, exp_pix(words[k], m, wl, bus, nar, 1'b0));
                if (wl == 2'd0) begin
                    strobe(); chk("R3", pan_data, exp_pix(words[k], m, wl, bus, nar, 1'b1));
                end
            end
            strobe(); chk("R9 empty strobe", pan_data, 0);
            chk("R9 flag", underflow, 1);
        end

        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule